// File: doc/BRIEF.md
# Modem Line Control and Status Register Pair

This block holds the modem control and modem status registers of a 16550-style serial port. Four modem input lines (clear-to-send, data-set-ready, carrier detect and ring indicator) pass through a flop synchroniser. The block then compares each line with the value it held one cycle earlier. A line that changed sets a sticky change flag. The flags stay set until the status register is read.

The control register drives the RTS, DTR, OUT1 and OUT2 outputs. Its loop bit turns on a self-test mode. In that mode the control bits are fed back into the status register in place of the external lines, and the external outputs are held inactive. A single flag reports whether any change flag is pending, and the port's interrupt logic can use it as the modem-status request.

All line and output signals are active high. Status reads are marked by a one-cycle read strobe. The value on the status read port during that strobe cycle is the value the reader gets. The clearing takes effect at the clock edge that ends the strobe cycle.

Top module: `modem_ctl_status`

## Requirements
- R1: After reset the status read port shows 0xB0 (carrier bit 7, data-set-ready bit 5 and clear-to-send bit 4 set, ring bit 6 clear, bits 3:0 zero), the control read port shows 0x08 and any_delta is low.
- R2: Outside loopback, status bits 7:4 show carrier, ring, data-set-ready and clear-to-send, in that order from the top bit. A line change reaches the status port after the third rising clock edge that follows it, and not earlier.
- R3: Status bit 3 (carrier change), bit 1 (data-set-ready change) and bit 0 (clear-to-send change) are set by any transition of their line. All change bits are sticky, and a second change is ORed into the ones already pending.
- R4: Status bit 2 is set only when the ring line falls from 1 to 0; a rising ring line never sets it.
- R5: A status read outside loopback clears bits 3:0 and leaves bits 7:4 unchanged. A change that lands on the same edge as the clearing read is kept.
- R6: A control write keeps only data bits 4:0 (bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2, bit 4 loop). It reads back with bits 7:5 zero, and outside loopback the outputs follow it one edge after the write.
- R7: With the loop bit set, status reads return OUT2 on bit 7, OUT1 on bit 6, DTR on bit 5 and RTS on bit 4, with bits 3:0 zero. All four external control outputs are low.
- R8: While the loop bit is set, changes on the external lines set no change bit, and status reads clear none. Pending change bits reappear once the loop bit is cleared.
- R9: any_delta is high exactly when at least one change bit is pending; outside loopback it equals the OR of status bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control register read value |
| sts_re | input | 1 | Status read strobe (clears change bits) |
| sts_rdata | output | 8 | Status register read value |
| cts_in | input | 1 | Clear-to-send line |
| dsr_in | input | 1 | Data-set-ready line |
| dcd_in | input | 1 | Carrier detect line |
| ri_in | input | 1 | Ring indicator line |
| rts_out | output | 1 | Request-to-send output |
| dtr_out | output | 1 | Data-terminal-ready output |
| out1_out | output | 1 | General output 1 |
| out2_out | output | 1 | General output 2 |
| any_delta | output | 1 | Some change bit is pending |

## Verification
A line change at the inputs passes two synchroniser flops and then the line and change registers. It therefore shows on the status port only after the third rising edge. The bench samples one edge early to confirm the old value is still there, and samples again at the third edge to confirm the new one. Control writes and read-clears act at the next edge, so their results are checked at the falling edge that follows. The read value itself is taken during the strobe cycle, before the clearing edge. The same-edge collision of a read and an arriving change is set up by starting the read two edges after the line moves.

// File: rtl/modem_ctl_status.sv
module modem_ctl_status #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] LINE_RST    = 4'b1011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       sts_re,
  output logic [7:0] sts_rdata,
  input  logic       cts_in,
  input  logic       dsr_in,
  input  logic       dcd_in,
  input  logic       ri_in,
  output logic       rts_out,
  output logic       dtr_out,
  output logic       out1_out,
  output logic       out2_out,
  output logic       any_delta
);

  localparam int         CTL_W   = 5;
  localparam logic [4:0] CTL_RST = 5'b01000;

  logic [3:0]       sync_q [SYNC_STAGES];
  logic [3:0]       line_now;
  logic [3:0]       line_q;
  logic [3:0]       delta_q;
  logic [3:0]       chg;
  logic [3:0]       new_d;
  logic [CTL_W-1:0] ctl_q;
  logic             loop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= LINE_RST;
    end else begin
      sync_q[0] <= {dcd_in, ri_in, dsr_in, cts_in};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign line_now = sync_q[SYNC_STAGES-1];
  assign loop     = ctl_q[4];
  assign chg      = line_q ^ line_now;
  assign new_d    = {chg[3], line_q[2] & ~line_now[2], chg[1], chg[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q  <= LINE_RST;
      delta_q <= '0;
      ctl_q   <= CTL_RST;
    end else begin
      line_q <= line_now;
      if (!loop) delta_q <= (sts_re ? 4'b0000 : delta_q) | new_d;
      if (ctl_we) ctl_q <= ctl_wdata[CTL_W-1:0];
    end
  end

  assign sts_rdata = loop ? {ctl_q[3], ctl_q[2], ctl_q[0], ctl_q[1], 4'b0000}
                          : {line_q, delta_q};
  assign ctl_rdata = {{(8-CTL_W){1'b0}}, ctl_q};
  assign dtr_out   = ctl_q[0] & ~loop;
  assign rts_out   = ctl_q[1] & ~loop;
  assign out1_out  = ctl_q[2] & ~loop;
  assign out2_out  = ctl_q[3] & ~loop;
  assign any_delta = |delta_q;

endmodule

// File: rtl/modem_ctl_status_chk.sv
module modem_ctl_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_we,
  input logic [7:0] ctl_wdata,
  input logic [7:0] ctl_rdata,
  input logic       sts_re,
  input logic [7:0] sts_rdata,
  input logic [3:0] line_now,
  input logic [3:0] line_q,
  input logic [3:0] delta_q,
  input logic       rts_out,
  input logic       dtr_out,
  input logic       out1_out,
  input logic       out2_out,
  input logic       any_delta
);

  AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> ctl_rdata == {3'b000, $past(ctl_wdata[4:0])}); // R6

  AST_LOOP_OUTS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[4] |-> !(rts_out | dtr_out | out1_out | out2_out)); // R7

  AST_LOOP_NO_DELTA: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[4] |=> $stable(delta_q)); // R8

  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[4] |-> any_delta == (|sts_rdata[3:0])); // R9

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_re && !ctl_rdata[4] && line_now == line_q) |=> delta_q == 4'b0000); // R5

  AST_RI_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_rdata[4] && !line_q[2] && line_now[2] && !delta_q[2]) |=> !delta_q[2]); // R4

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_rdata[4] && !sts_re) |=> (delta_q & $past(delta_q)) == $past(delta_q)); // R3

endmodule

bind modem_ctl_status modem_ctl_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .ctl_rdata(ctl_rdata), .sts_re(sts_re), .sts_rdata(sts_rdata),
  .line_now(line_now), .line_q(line_q), .delta_q(delta_q),
  .rts_out(rts_out), .dtr_out(dtr_out), .out1_out(out1_out),
  .out2_out(out2_out), .any_delta(any_delta)
);

// File: tb/sim_modem_ctl_status.sv
`timescale 1ns/1ps
module sim_modem_ctl_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic sts_re = 1'b0;
  logic [7:0] sts_rdata;
  logic [3:0] lines = 4'b1011;
  logic rts_out, dtr_out, out1_out, out2_out, any_delta;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  modem_ctl_status u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .sts_re(sts_re), .sts_rdata(sts_rdata),
    .cts_in(lines[0]), .dsr_in(lines[1]), .dcd_in(lines[3]), .ri_in(lines[2]),
    .rts_out(rts_out), .dtr_out(dtr_out), .out1_out(out1_out),
    .out2_out(out2_out), .any_delta(any_delta)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic rd(output logic [7:0] v);
    sts_re = 1'b1;
    #1 v = sts_rdata;
    @(posedge clk);
    @(negedge clk);
    sts_re = 1'b0;
  endtask

  task automatic wr(input logic [7:0] v);
    ctl_we = 1'b1;
    ctl_wdata = v;
    tick(1);
    ctl_we = 1'b0;
  endtask

  function automatic logic [3:0] exp_delta(input logic [3:0] o, input logic [3:0] n);
    logic [3:0] x;
    x = o ^ n;
    return {x[3], o[2] & ~n[2], x[1], x[0]};
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    @(negedge clk);
    tick(2);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 status", sts_rdata, 8'hB0);
    check("R1 control", ctl_rdata, 8'h08);
    check("R1 any_delta", any_delta, 0);
    check("R6 reset outputs", {out2_out, out1_out, rts_out, dtr_out}, 4'b1000);

    // R2 R3 R4 R5 R9 sweep over every old/new line pair
    for (int o = 0; o < 16; o++) begin
      for (int n = 0; n < 16; n++) begin
        lines = o[3:0];
        tick(4);
        rd(v);
        tick(1);
        lines = n[3:0];
        tick(2);
        check("R2 latency", sts_rdata, {o[3:0], 4'b0000});
        tick(1);
        check("R2 R3 R4 status", sts_rdata, {n[3:0], exp_delta(o[3:0], n[3:0])});
        check("R9 any_delta", any_delta, (o != n) && (exp_delta(o[3:0], n[3:0]) != 0));
        rd(v);
        check("R5 read value", v, {n[3:0], exp_delta(o[3:0], n[3:0])});
        check("R5 cleared", sts_rdata, {n[3:0], 4'b0000});
      end
    end

    // R3 accumulation
    lines = 4'b1011; tick(4); rd(v);
    lines = 4'b1010; tick(3);
    lines = 4'b1000; tick(3);
    check("R3 or-accumulate", sts_rdata, 8'h83);
    rd(v);

    // R5 read collides with arriving change
    lines = 4'b0000; tick(2);
    rd(v);
    check("R5 same-edge change kept", sts_rdata, 8'h08);
    rd(v);

    // R6 R7 control sweep
    lines = 4'b0101; tick(4); rd(v);
    for (int w = 0; w < 256; w++) begin
      wr(w[7:0]);
      check("R6 readback", ctl_rdata, w & 8'h1F);
      if (w[4]) begin
        check("R7 outputs low", {out2_out, out1_out, rts_out, dtr_out}, 0);
        check("R7 loop status", sts_rdata, {w[3], w[2], w[0], w[1], 4'b0000});
      end else begin
        check("R6 outputs", {out2_out, out1_out, rts_out, dtr_out}, w[3:0]);
        check("R2 status normal", sts_rdata, 8'h50);
      end
    end

    // R8 loopback ignores lines and reads
    wr(8'h00);
    lines = 4'b0100; tick(3);
    check("R8 setup delta", sts_rdata, 8'h41);
    wr(8'h10);
    lines = 4'b1011; tick(4);
    lines = 4'b0000; tick(4);
    check("R8 loop any_delta held", any_delta, 1);
    rd(v);
    check("R8 loop read value", v, 8'h00);
    wr(8'h00);
    check("R8 deltas kept", sts_rdata, 8'h01);
    check("R9 after loop", any_delta, 1);
    rd(v);
    check("R5 final clear", sts_rdata, 8'h00);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule